// File: doc/BRIEF.md
# Match Timer with Prescaler

This block is a 32-bit up-counting timer that software reaches over a simple register bus. A prescale divider sets how often the counter steps, and one compare value decides when a match event fires. On a match the block latches a pending flag. Three separate control bits decide what else the match does: drive the interrupt output, send the counter back to zero, or halt counting. Any mix of the three is allowed.

A typical reprogramming sequence has four steps. Software sets the hold bit so that the counter and prescaler sit at zero. It then loads the prescale value, the compare value and the match actions. Finally it writes the run bit alone, and counting starts from zero. Register reads are combinational from the addressed register. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. A read of an unmapped offset (for example 0x40) returns 0.
- R2: Byte offsets are: pending flag 0x00, timer control 0x04, counter 0x08, prescale 0x0C, match actions 0x14, compare value 0x18, count mode 0x70. Written fields read back unchanged. The counter is also writable, and a write to it wins over counting.
- R3: In timer control, bit 1 (hold) keeps the counter and prescaler at 0 on every edge while it is set, even when bit 0 (run) is also set.
- R4: With prescale value N and counting active, the counter steps once every N+1 clocks. The first step comes N+1 edges after the edge that writes run=1 and releases hold.
- R5: The counter wraps from 0xFFFFFFFF to 0.
- R6: A match exists only while counting is active and the counter equals the compare value. Match at a value of 0 counts. When bit 1 of the match actions is set, the step that follows a match loads 0 instead of value+1.
- R7: When bit 2 of the match actions is set, a match clears the run bit at the next edge and the counter stays frozen at the compare value. If bit 1 is also set, it freezes at 0 instead. A software write to timer control in the same cycle wins over this.
- R8: Every match sets bit 0 of the pending flag register. `irq_o` is high exactly when that flag is set and bit 0 of the match actions is set.
- R9: Writing 1 to bit 0 of the pending flag clears it, and writing 0 has no effect. A match in the same cycle as a clearing write leaves the flag set.
- R10: The count mode is a 2-bit field. Only value 0 lets the counter and prescaler advance. Any other value freezes them and produces no matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register, 0 when not selected |
| irq_o | output | 1 | Interrupt request |

## Verification
Several boundary cases are targeted directly. One is the count on the exact match edge versus the edge after it: a design that resets on the match itself instead of on the following step would never show the compare value. Another is the frozen value under stop, with and without reset-on-match: a design that lets the stopping step through would read value+1. Further checks cover a compare value of 0, a prescaled match that holds its value for N+1 cycles, and a clearing write that lands on a match. A design that gives the clear priority would lose that event. The tests also cover hold overriding run, a nonzero mode freezing the count, the wrap past all ones, and an interrupt that drops when its enable bit is cleared while the flag stays pending.

// File: rtl/mtm_pkg.sv
`timescale 1ns/1ps
package mtm_pkg;

    localparam int unsigned MTM_AW = 8;

    // Byte offsets decoded by software
    localparam logic [MTM_AW-1:0] OFS_FLAG = 8'h00;
    localparam logic [MTM_AW-1:0] OFS_CTL  = 8'h04;
    localparam logic [MTM_AW-1:0] OFS_CNT  = 8'h08;
    localparam logic [MTM_AW-1:0] OFS_PRE  = 8'h0C;
    localparam logic [MTM_AW-1:0] OFS_MCTL = 8'h14;
    localparam logic [MTM_AW-1:0] OFS_MVAL = 8'h18;
    localparam logic [MTM_AW-1:0] OFS_MODE = 8'h70;

    // Timer control: bit 1 hold, bit 0 run
    typedef struct packed {
        logic hold;
        logic run;
    } tctl_t;

    // Match actions: bit 2 stop, bit 1 zero, bit 0 irq
    typedef struct packed {
        logic stop_on;
        logic zero_on;
        logic irq_on;
    } mctl_t;

    typedef enum logic [1:0] {
        CM_TIMER = 2'd0,
        CM_RSV1  = 2'd1,
        CM_RSV2  = 2'd2,
        CM_RSV3  = 2'd3
    } cmode_t;

    typedef enum logic [2:0] {
        RS_NONE, RS_FLAG, RS_CTL, RS_CNT, RS_PRE, RS_MCTL, RS_MVAL, RS_MODE
    } regsel_t;

    function automatic regsel_t reg_decode(logic [MTM_AW-1:0] a);
        case (a)
            OFS_FLAG: return RS_FLAG;
            OFS_CTL:  return RS_CTL;
            OFS_CNT:  return RS_CNT;
            OFS_PRE:  return RS_PRE;
            OFS_MCTL: return RS_MCTL;
            OFS_MVAL: return RS_MVAL;
            OFS_MODE: return RS_MODE;
            default:  return RS_NONE;
        endcase
    endfunction

    function automatic logic is_counting(tctl_t c, cmode_t m);
        return c.run && !c.hold && (m == CM_TIMER);
    endfunction

endpackage

// File: rtl/mtm_regs.sv
`timescale 1ns/1ps
module mtm_regs
    import mtm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [MTM_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     cnt_q,
    input  logic              match_evt,
    output tctl_t             ctl_q,
    output mctl_t             mctl_q,
    output logic [DW-1:0]     pre_q,
    output logic [DW-1:0]     mval_q,
    output cmode_t            mode_q,
    output logic              flag_q,
    output logic              cnt_wr
);

    localparam int CTLW  = $bits(tctl_t);
    localparam int MCTLW = $bits(mctl_t);
    localparam int MODEW = $bits(cmode_t);

    regsel_t sel;
    logic    wr_en;

    assign sel    = reg_decode(bus_addr);
    assign wr_en  = bus_sel && bus_wr;
    assign cnt_wr = wr_en && (sel == RS_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            mctl_q <= '0;
            pre_q  <= '0;
            mval_q <= '0;
            mode_q <= CM_TIMER;
            flag_q <= 1'b0;
        end else begin
            // software write wins over the hardware stop
            if (wr_en && sel == RS_CTL)
                ctl_q <= tctl_t'(bus_wdata[CTLW-1:0]);
            else if (match_evt && mctl_q.stop_on)
                ctl_q.run <= 1'b0;

            if (wr_en && sel == RS_PRE)  pre_q  <= bus_wdata;
            if (wr_en && sel == RS_MVAL) mval_q <= bus_wdata;
            if (wr_en && sel == RS_MCTL) mctl_q <= mctl_t'(bus_wdata[MCTLW-1:0]);
            if (wr_en && sel == RS_MODE) mode_q <= cmode_t'(bus_wdata[MODEW-1:0]);

            // a new match outranks a clearing write
            if (match_evt)
                flag_q <= 1'b1;
            else if (wr_en && sel == RS_FLAG && bus_wdata[0])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (sel)
                RS_FLAG: bus_rdata = {{(DW-1){1'b0}}, flag_q};
                RS_CTL:  bus_rdata = {{(DW-CTLW){1'b0}}, ctl_q};
                RS_CNT:  bus_rdata = cnt_q;
                RS_PRE:  bus_rdata = pre_q;
                RS_MCTL: bus_rdata = {{(DW-MCTLW){1'b0}}, mctl_q};
                RS_MVAL: bus_rdata = mval_q;
                RS_MODE: bus_rdata = {{(DW-MODEW){1'b0}}, mode_q};
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mtm_prescale.sv
`timescale 1ns/1ps
module mtm_prescale #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    input  logic [DW-1:0] pre_val,
    output logic          tick_o
);

    logic [DW-1:0] pc_q;

    // >= keeps a shrunken limit from running the divider the long way round
    assign tick_o = adv && (pc_q >= pre_val);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pc_q <= '0;
        else if (adv)
            pc_q <= tick_o ? '0 : pc_q + 1'b1;
    end

endmodule

// File: rtl/mtm_count.sv
`timescale 1ns/1ps
module mtm_count #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          active,
    input  logic          tick,
    input  logic          stop_on,
    input  logic          zero_on,
    input  logic [DW-1:0] mval,
    input  logic          sw_wr,
    input  logic [DW-1:0] sw_data,
    output logic [DW-1:0] cnt_q,
    output logic          match_o
);

    assign match_o = active && (cnt_q == mval);

    always_ff @(posedge clk) begin
        if (rst || hold)
            cnt_q <= '0;
        else if (sw_wr)
            cnt_q <= sw_data;
        else if (match_o && stop_on)
            cnt_q <= zero_on ? '0 : cnt_q;
        else if (tick)
            cnt_q <= (match_o && zero_on) ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer
    import mtm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [MTM_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o
);

    tctl_t         ctl_q;
    mctl_t         mctl_q;
    cmode_t        mode_q;
    logic [DW-1:0] pre_q;
    logic [DW-1:0] mval_q;
    logic [DW-1:0] cnt_q;
    logic          flag_q;
    logic          cnt_wr_w;
    logic          match_w;
    logic          tick_w;
    logic          active_w;
    logic          pclr_w;

    assign active_w = is_counting(ctl_q, mode_q);
    assign pclr_w   = ctl_q.hold || (match_w && mctl_q.stop_on);
    assign irq_o    = flag_q && mctl_q.irq_on;

    mtm_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_q     (cnt_q),
        .match_evt (match_w),
        .ctl_q     (ctl_q),
        .mctl_q    (mctl_q),
        .pre_q     (pre_q),
        .mval_q    (mval_q),
        .mode_q    (mode_q),
        .flag_q    (flag_q),
        .cnt_wr    (cnt_wr_w)
    );

    mtm_prescale #(.DW(DW)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clr     (pclr_w),
        .adv     (active_w),
        .pre_val (pre_q),
        .tick_o  (tick_w)
    );

    mtm_count #(.DW(DW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .hold    (ctl_q.hold),
        .active  (active_w),
        .tick    (tick_w),
        .stop_on (mctl_q.stop_on),
        .zero_on (mctl_q.zero_on),
        .mval    (mval_q),
        .sw_wr   (cnt_wr_w),
        .sw_data (bus_wdata),
        .cnt_q   (cnt_q),
        .match_o (match_w)
    );

endmodule

// File: rtl/mtm_checker.sv
`timescale 1ns/1ps
module mtm_checker
    import mtm_pkg::*;
#(
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [MTM_AW-1:0] bus_addr,
    input logic              bus_wdata0,
    input tctl_t             ctl_q,
    input mctl_t             mctl_q,
    input logic              flag_q,
    input logic [DW-1:0]     cnt_q,
    input logic              match_w,
    input logic              tick_w,
    input logic              active_w,
    input logic              irq_o
);

    logic ctl_wr, cnt_wr, flag_wr;
    assign ctl_wr  = bus_sel && bus_wr && (bus_addr == OFS_CTL);
    assign cnt_wr  = bus_sel && bus_wr && (bus_addr == OFS_CNT);
    assign flag_wr = bus_sel && bus_wr && (bus_addr == OFS_FLAG);

    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_q.hold |=> (cnt_q == '0));

    assert_zero_on_match_R6: assert property (@(posedge clk) disable iff (rst)
        (match_w && mctl_q.zero_on && tick_w && !cnt_wr) |=> (cnt_q == '0));

    assert_stop_clears_run_R7: assert property (@(posedge clk) disable iff (rst)
        (match_w && mctl_q.stop_on && !ctl_wr) |=> !ctl_q.run);

    assert_match_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
        match_w |=> flag_q);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (flag_q && mctl_q.irq_on));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(flag_wr && bus_wdata0)) |=> flag_q);

    assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (!active_w && !ctl_q.hold && !cnt_wr) |=> $stable(cnt_q));

endmodule

bind match_timer mtm_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata0 (bus_wdata[0]),
    .ctl_q      (ctl_q),
    .mctl_q     (mctl_q),
    .flag_q     (flag_q),
    .cnt_q      (cnt_q),
    .match_w    (match_w),
    .tick_w     (tick_w),
    .active_w   (active_w),
    .irq_o      (irq_o)
);

// File: tb/sim_match_timer.sv
`timescale 1ns/1ps
module sim_match_timer;
    import mtm_pkg::*;

    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [MTM_AW-1:0] bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic              irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    match_timer #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [31:0] pre;
        logic [31:0] mval;
        logic [2:0]  mctl;
        logic [15:0] k;
        logic [31:0] cnt;
        logic        flag;
        logic        run;
    } vec_t;

    // pre, compare, actions{stop,zero,irq}, edges after enable, count, flag, run
    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'd0, 32'd1000, 3'b000, 16'd10, 32'd10, 1'b0, 1'b1},
        '{32'd3, 32'd1000, 3'b000, 16'd10, 32'd2,  1'b0, 1'b1},
        '{32'd0, 32'd5,    3'b011, 16'd5,  32'd5,  1'b0, 1'b1},
        '{32'd0, 32'd5,    3'b011, 16'd6,  32'd0,  1'b1, 1'b1},
        '{32'd0, 32'd5,    3'b011, 16'd9,  32'd3,  1'b1, 1'b1},
        '{32'd0, 32'd5,    3'b101, 16'd20, 32'd5,  1'b1, 1'b0},
        '{32'd0, 32'd5,    3'b100, 16'd20, 32'd5,  1'b1, 1'b0},
        '{32'd0, 32'd5,    3'b110, 16'd20, 32'd0,  1'b1, 1'b0},
        '{32'd1, 32'd3,    3'b010, 16'd7,  32'd3,  1'b1, 1'b1},
        '{32'd1, 32'd3,    3'b010, 16'd10, 32'd1,  1'b1, 1'b1},
        '{32'd0, 32'd0,    3'b001, 16'd3,  32'd3,  1'b1, 1'b1},
        '{32'd2, 32'd2,    3'b101, 16'd20, 32'd2,  1'b1, 1'b0}
    };

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [MTM_AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // call in the low phase; returns before the next edge
    task automatic rd(logic [MTM_AW-1:0] a, output logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.3;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_edges(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] c, f, r;

        wait_edges(4);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        rd(OFS_FLAG, d); check("R1 flag", d, 0);
        rd(OFS_CTL,  d); check("R1 ctl", d, 0);
        rd(OFS_CNT,  d); check("R1 cnt", d, 0);
        rd(OFS_PRE,  d); check("R1 pre", d, 0);
        rd(OFS_MCTL, d); check("R1 mctl", d, 0);
        rd(OFS_MVAL, d); check("R1 mval", d, 0);
        rd(OFS_MODE, d); check("R1 mode", d, 0);
        rd(8'h40,    d); check("R1 unmapped", d, 0);
        check("R1 irq", {31'd0, irq_o}, 0);

        // R2 readback at the fixed offsets
        wr(OFS_CTL, 32'd2);
        wr(OFS_PRE, 32'hA5A5_0001);
        wr(OFS_MVAL, 32'h0001_2345);
        wr(OFS_MCTL, 32'h7);
        wr(OFS_MODE, 32'h3);
        @(negedge clk);
        rd(OFS_CTL,  d); check("R2 ctl", d, 32'd2);
        rd(OFS_PRE,  d); check("R2 pre", d, 32'hA5A5_0001);
        rd(OFS_MVAL, d); check("R2 mval", d, 32'h0001_2345);
        rd(OFS_MCTL, d); check("R2 mctl", d, 32'h7);
        rd(OFS_MODE, d); check("R2 mode", d, 32'h3);
        wr(OFS_MODE, 32'h0);

        // vector table: R4 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            wr(OFS_CTL, 32'd2);
            wr(OFS_FLAG, 32'd1);
            wr(OFS_PRE, VECS[v].pre);
            wr(OFS_MVAL, VECS[v].mval);
            wr(OFS_MCTL, {29'd0, VECS[v].mctl});
            wr(OFS_CTL, 32'd1);
            wait_edges(int'(VECS[v].k));
            @(negedge clk);
            rd(OFS_CNT, c);
            rd(OFS_FLAG, f);
            rd(OFS_CTL, r);
            check($sformatf("R4/R6 vec%0d count", v), c, VECS[v].cnt);
            check($sformatf("R8 vec%0d flag", v), f, {31'd0, VECS[v].flag});
            check($sformatf("R7 vec%0d run", v), r, {31'd0, VECS[v].run});
            check($sformatf("R8 vec%0d irq", v), {31'd0, irq_o},
                  {31'd0, VECS[v].flag & VECS[v].mctl[0]});
        end

        // R3 hold wins over run
        wr(OFS_MCTL, 32'd0);
        wr(OFS_PRE, 32'd0);
        wr(OFS_CTL, 32'd3);
        wait_edges(6);
        @(negedge clk);
        rd(OFS_CNT, d); check("R3 hold with run", d, 0);

        // R10 nonzero mode freezes the count
        wr(OFS_CTL, 32'd2);
        wr(OFS_MODE, 32'd1);
        wr(OFS_CTL, 32'd1);
        wait_edges(8);
        @(negedge clk);
        rd(OFS_CNT, d); check("R10 mode1 frozen", d, 0);
        wr(OFS_MODE, 32'd0);
        wait_edges(4);
        @(negedge clk);
        rd(OFS_CNT, d); check("R10 mode0 counts", d, 32'd4);

        // R5 wrap, R2 counter write while running
        wr(OFS_CNT, 32'hFFFF_FFFE);
        wait_edges(3);
        @(negedge clk);
        rd(OFS_CNT, d); check("R5 wrap", d, 32'd1);

        // R8 R9 interrupt gating and clearing
        wr(OFS_CTL, 32'd2);
        wr(OFS_MVAL, 32'd0);
        wr(OFS_MCTL, 32'b011);
        wr(OFS_FLAG, 32'd1);
        wr(OFS_CTL, 32'd1);
        wait_edges(3);
        @(negedge clk);
        check("R8 irq high", {31'd0, irq_o}, 1);
        wr(OFS_FLAG, 32'd1);
        @(negedge clk);
        rd(OFS_FLAG, d); check("R9 match beats clear", d, 1);
        wr(OFS_MCTL, 32'b010);
        @(negedge clk);
        check("R8 irq masked", {31'd0, irq_o}, 0);
        rd(OFS_FLAG, d); check("R8 flag kept", d, 1);
        wr(OFS_CTL, 32'd2);
        wr(OFS_FLAG, 32'd0);
        @(negedge clk);
        rd(OFS_FLAG, d); check("R9 write0 ignored", d, 1);
        wr(OFS_FLAG, 32'd1);
        @(negedge clk);
        rd(OFS_FLAG, d); check("R9 cleared", d, 0);

        finish_run();
    end

endmodule